// File: doc/BRIEF.md
# Powerdown Exit Sequencer

This block sits next to a small processor core and controls how the core leaves its low-power halt state. While the core runs, a falling edge on the active-low powerdown pin raises a one-cycle interrupt request. The core enters powerdown only when it later reports that it has executed its halt instruction. From then on the core clock enable stays low.

A wake comes from either a rising edge on the powerdown pin or the system reset request. On a wake the block captures two bits of the powerdown control word. Bit 14 picks the start-up wait: 100 cycles when clear, 4096 cycles when set. Bit 12 picks the wake context. When bit 12 is clear the core resumes at the instruction after the halt. When it is set the context is cleared: the hardware stacks are flushed, the interrupt mask and arithmetic status are loaded with zero, the system status is loaded with 0x55, and the next PC is forced to address zero. A reset wake always uses the cleared context.

The pin is synchronized with two flops, and both of its edges are detected on the synchronized value. The sequence goes through four states: running, powered down, start-up wait and a one-cycle release. The context-clear strobes are issued during the release cycle, one cycle before the clock enable returns.

Top module: `pdwn_exit_ctl`

## Requirements
- R1: After block reset `core_clk_en` is 1, and `pd_irq`, `stk_flush`, `reg_ld` and `pc_zero` are 0.
- R2: While running, a falling edge on `pd_n` produces exactly one `pd_irq` pulse, seen two cycles after the pin changes. The clock stays enabled.
- R3: While running, a `halt_exec` strobe drops `core_clk_en` on the next cycle. `core_clk_en` then stays low until a wake completes. A `pd_n` rising edge while running has no effect: the clock stays on and no strobe is issued.
- R4: With `pd_ctl` bit 14 at 0, a `pd_n` rising edge in powerdown brings `core_clk_en` back 104 cycles after the pin change. This is 100 wait cycles plus synchronizer, entry and release.
- R5: With `pd_ctl` bit 14 at 1, the same pin wake brings `core_clk_en` back 4100 cycles after the pin change, giving a 4096-cycle wait.
- R6: With `pd_ctl` bit 12 at 0, a pin wake issues no `stk_flush`, `reg_ld` or `pc_zero`. The core resumes in place.
- R7: With `pd_ctl` bit 12 at 1, `stk_flush`, `reg_ld` and `pc_zero` pulse together for exactly one cycle, the cycle before `core_clk_en` returns. In that cycle `sstat_val` is 0x55 and `imask_val` and `astat_val` are 0.
- R8: A one-cycle `sys_rst` in powerdown wakes the core with the cleared context whatever bit 12 holds. `core_clk_en` returns (wait + 2) cycles after `sys_rst` is raised.
- R9: When `sys_rst` coincides with a pin wake, the reset wins. The cleared context is used, and timing is counted from the reset.
- R10: Bits 14 and 12 are sampled at the wake. Changes to `pd_ctl` during the wait change neither the wait length nor the context.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| pd_n | input | 1 | Asynchronous active-low powerdown pin |
| sys_rst | input | 1 | Synchronous system reset request, active high |
| halt_exec | input | 1 | Core executed its halt instruction (one-cycle strobe) |
| pd_ctl | input | CTL_W | Powerdown control word; bit 14 long wait, bit 12 cleared context |
| core_clk_en | output | 1 | Core clock enable |
| pd_irq | output | 1 | Powerdown interrupt request pulse |
| stk_flush | output | 1 | Flush PC, status, loop and counter stacks |
| reg_ld | output | 1 | Load strobe for the three register values |
| imask_val | output | IMASK_W | Interrupt mask load value (zero) |
| astat_val | output | ASTAT_W | Arithmetic status load value (zero) |
| sstat_val | output | SSTAT_W | System status load value (0x55 during load) |
| pc_zero | output | 1 | Force next PC to address zero |

## Verification
Any error in the state or the wait counter shows up as a change in the cycle at which `core_clk_en` rises after a wake. That cycle is measured exactly against 104, 4100, 102 or 4098 cycles, so an off-by-one is caught within one wake. A wrong context latch shows up in the release cycle: strobes appear on a resume wake, are missing on a cleared wake, or `sstat_val` is not 0x55. A synchronizer or edge-detector fault either moves or duplicates the `pd_irq` pulse two cycles after a pin fall, or it lets a pin wake start early or never.

// File: rtl/pdwn_exit_ctl.sv
module pdwn_exit_ctl #(
  parameter int CTL_W      = 16,
  parameter int DLY_BIT    = 14,
  parameter int CTX_BIT    = 12,
  parameter int QUICK_CYC  = 100,
  parameter int LONG_CYC   = 4096,
  parameter int IMASK_W    = 10,
  parameter int ASTAT_W    = 8,
  parameter int SSTAT_W    = 8,
  parameter logic [SSTAT_W-1:0] SSTAT_INIT = 8'h55
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pd_n,
  input  logic               sys_rst,
  input  logic               halt_exec,
  input  logic [CTL_W-1:0]   pd_ctl,
  output logic               core_clk_en,
  output logic               pd_irq,
  output logic               stk_flush,
  output logic               reg_ld,
  output logic [IMASK_W-1:0] imask_val,
  output logic [ASTAT_W-1:0] astat_val,
  output logic [SSTAT_W-1:0] sstat_val,
  output logic               pc_zero
);
  localparam int CNT_W = $clog2(LONG_CYC > QUICK_CYC ? LONG_CYC : QUICK_CYC);

  typedef enum logic [1:0] {S_RUN, S_PDWN, S_DLY, S_REL} st_t;

  st_t              st;
  logic [1:0]       pin_sync;
  logic             pin_prev;
  logic             long_q, clr_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic             pin_rise, pin_fall, wake, strobe;
  logic             unused_ctl;

  assign pin_rise = pin_sync[1] & ~pin_prev;
  assign pin_fall = ~pin_sync[1] & pin_prev;
  assign wake     = sys_rst | ((st == S_PDWN) & pin_rise);
  assign lim      = long_q ? CNT_W'(LONG_CYC - 1) : CNT_W'(QUICK_CYC - 1);
  assign unused_ctl = ^pd_ctl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_sync <= 2'b11;
      pin_prev <= 1'b1;
      st       <= S_RUN;
      long_q   <= 1'b0;
      clr_q    <= 1'b0;
      cnt      <= '0;
    end else begin
      pin_sync <= {pin_sync[0], pd_n};
      pin_prev <= pin_sync[1];
      if (wake) begin
        st     <= S_DLY;
        cnt    <= '0;
        long_q <= pd_ctl[DLY_BIT];
        clr_q  <= sys_rst | pd_ctl[CTX_BIT];
      end else begin
        case (st)
          S_RUN:  if (halt_exec) st <= S_PDWN;
          S_PDWN: ;
          S_DLY:  if (cnt == lim) st <= S_REL; else cnt <= cnt + 1'b1;
          S_REL:  st <= S_RUN;
          default: st <= S_RUN;
        endcase
      end
    end
  end

  assign core_clk_en = (st == S_RUN);
  assign pd_irq      = (st == S_RUN) & pin_fall;
  assign strobe      = (st == S_REL) & clr_q;
  assign stk_flush   = strobe;
  assign reg_ld      = strobe;
  assign pc_zero     = strobe;
  assign imask_val   = '0;
  assign astat_val   = '0;
  assign sstat_val   = strobe ? SSTAT_INIT : '0;

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pd_irq |=> !pd_irq); // R2
  AST_HALT_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    (core_clk_en && halt_exec) |=> !core_clk_en); // R3
  AST_WAKE_VIA_REL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_clk_en) |-> $past(st == S_REL)); // R4
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DLY) |-> (cnt <= lim)); // R5
  AST_STROBE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    stk_flush |=> (!stk_flush && core_clk_en)); // R7
  AST_RST_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> (!core_clk_en && clr_q)); // R8
endmodule

// File: tb/test_pdwn_exit_ctl.sv
module test_pdwn_exit_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pd_n = 1'b1;
  logic        sys_rst = 1'b0;
  logic        halt_exec = 1'b0;
  logic [15:0] pd_ctl = '0;
  logic        core_clk_en, pd_irq, stk_flush, reg_ld, pc_zero;
  logic [9:0]  imask_val;
  logic [7:0]  astat_val, sstat_val;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  pdwn_exit_ctl i_pdwn_exit_ctl (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .sys_rst(sys_rst),
    .halt_exec(halt_exec), .pd_ctl(pd_ctl), .core_clk_en(core_clk_en),
    .pd_irq(pd_irq), .stk_flush(stk_flush), .reg_ld(reg_ld),
    .imask_val(imask_val), .astat_val(astat_val), .sstat_val(sstat_val),
    .pc_zero(pc_zero));

  function automatic int exp_wait(input bit long_sel);
    return long_sel ? 4096 : 100;
  endfunction

  function automatic int exp_wake(input bit long_sel, input bit by_rst);
    return exp_wait(long_sel) + (by_rst ? 2 : 4);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      mismatched++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic go_halt(input bit pin_mode);
    int irqs = 0;
    if (pin_mode) begin
      @(negedge clk); pd_n = 1'b0;
      for (int i = 1; i <= 4; i++) begin
        @(negedge clk);
        if (pd_irq) begin
          irqs++;
          chk(i == 2, "R2 irq cycle", i, 2);
        end
        chk(core_clk_en == 1'b1, "R2 clock kept", core_clk_en, 1);
      end
      chk(irqs == 1, "R2 irq count", irqs, 1);
    end
    @(negedge clk); halt_exec = 1'b1;
    @(negedge clk); halt_exec = 1'b0;
    chk(core_clk_en == 1'b0, "R3 halt gates clock", core_clk_en, 0);
  endtask

  // mode: 0 pin wake, 1 reset wake, 2 pin wake with coincident reset
  task automatic wake(input int mode, input bit long_sel, input bit ctx_sel, input bit mid_change);
    int n = 0;
    int strobe_at = -1;
    int strobes = 0;
    bit val_ok = 1'b1;
    bit clr_exp = (mode != 0) || ctx_sel;
    int exp_n;
    string rq;
    rq = (mode == 1) ? "R8" : (mode == 2) ? "R9" : (long_sel ? "R5" : "R4");
    exp_n = exp_wake(long_sel, mode == 1);
    repeat ($urandom_range(0, 4)) begin
      @(negedge clk); halt_exec = 1'b1;
    end
    @(negedge clk);
    halt_exec = 1'b0;
    pd_ctl = $urandom();
    pd_ctl[14] = long_sel;
    pd_ctl[12] = ctx_sel;
    if (mode == 1) sys_rst = 1'b1; else pd_n = 1'b1;
    do begin
      @(negedge clk);
      n++;
      if (mode == 1 && n == 1) sys_rst = 1'b0;
      if (mode == 2 && n == 2) sys_rst = 1'b1;
      if (mode == 2 && n == 3) sys_rst = 1'b0;
      if (mid_change && n == 6) pd_ctl = ~pd_ctl;
      if (stk_flush || reg_ld || pc_zero) begin
        strobes++;
        strobe_at = n;
        if (!(stk_flush && reg_ld && pc_zero && sstat_val == 8'h55 &&
              imask_val == 0 && astat_val == 0)) val_ok = 1'b0;
      end
    end while (!core_clk_en && n < 5000);
    chk(n == exp_n, mid_change ? "R10 wait length" : rq, n, exp_n);
    if (clr_exp) begin
      chk(strobes == 1, "R7 strobe count", strobes, 1);
      chk(strobe_at == n - 1, "R7 strobe cycle", strobe_at, n - 1);
      chk(val_ok, "R7 load values", sstat_val, 8'h55);
    end else begin
      chk(strobes == 0, mid_change ? "R10 context" : "R6 no strobes", strobes, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(core_clk_en == 1'b1, "R1 clk_en", core_clk_en, 1);
    chk(!pd_irq && !stk_flush && !reg_ld && !pc_zero, "R1 quiet", stk_flush, 0);

    // R3: pin rise while running is ignored
    @(negedge clk); pd_n = 1'b0;
    repeat (4) @(negedge clk);
    pd_n = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(core_clk_en && !stk_flush, "R3 run rise ignored", core_clk_en, 1);
    end

    // directed corners
    go_halt(1'b1); wake(0, 1'b0, 1'b0, 1'b0);
    go_halt(1'b1); wake(0, 1'b0, 1'b1, 1'b0);
    go_halt(1'b1); wake(0, 1'b1, 1'b0, 1'b0);
    go_halt(1'b0); wake(1, 1'b0, 1'b0, 1'b0);
    go_halt(1'b1); wake(2, 1'b0, 1'b0, 1'b0);
    go_halt(1'b1); wake(0, 1'b0, 1'b0, 1'b1);
    go_halt(1'b0); wake(1, 1'b1, 1'b0, 1'b1);

    for (int t = 0; t < 24; t++) begin
      int mode = $urandom_range(0, 2);
      bit lng = ($urandom_range(0, 4) == 0);
      bit ctx = $urandom_range(0, 1);
      bit mid = $urandom_range(0, 1);
      go_halt(mode != 1);
      wake(mode, lng, ctx, mid);
      repeat ($urandom_range(1, 6)) @(negedge clk);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule